// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a serial memory on a two-wire bus. It samples the bus clock and data lines with the system clock. It recognises start and stop conditions and shifts in a control byte, a word address and data bytes. It answers with acknowledges by enabling an open-drain pull-down on the data line. The memory holds 1024 bytes. Reads are served straight from the array. Writes are collected in a 16-byte page stage and copied into the array after the closing stop condition.

While the copy and the programming hold time run, the engine withholds every acknowledge. A bus master can therefore poll with a write control byte until the engine answers. The device type code is fixed. The engine has no pin-strapped address. The middle bits of the control byte select the upper address bits.

Top module: `eeprom_twi_slave`

## Requirements
- R1: A data-line fall while the clock line is high is a start. A data-line rise while the clock line is high is a stop. A start at any point, including inside a byte, restarts reception with a control byte.
- R2: A control byte has the form {code[3:0], b2, b1, b0, rw}, sent MSB first. If the code is not 4'b1010, the engine gives no acknowledge and ignores all traffic until the next start.
- R3: The engine acknowledges by pulling the data line low through the high phase of the ninth clock. It does this for each accepted control byte, each word address byte and each write data byte.
- R4: While a page commit or its hold time is in progress, no control byte is acknowledged.
- R5: An accepted control byte loads b1:b0 into address pointer bits 9:8. b2 has no effect on any address.
- R6: The byte that follows a write control byte loads address pointer bits 7:0.
- R7: Each later write byte is stored at the pointer. Only pointer bits 3:0 then increment, wrapping inside the 16-byte page. A later byte that reaches the same location replaces the earlier one.
- R8: A stop that ends a write with at least one data byte copies the staged bytes into the array and starts the busy period. A write that ends after the address byte changes no memory and starts no busy period.
- R9: A read control byte with no address phase returns the byte at the pointer, which is the location after the last one accessed.
- R10: A write control byte, an address byte, a repeated start and a read control byte return the byte at that address.
- R11: Each master acknowledge after a read byte sends the next byte. The pointer increments over all 10 bits after each byte sent, so it wraps from 1023 to 0.
- R12: After a master non-acknowledge, the engine leaves the data line released until the next start.
- R13: The pull-down enable changes only while the sampled clock line is low. Read data goes out MSB first and is held through each clock high phase. The enable is low out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe_o | output | 1 | Pull-down enable for the open-drain data line (1 pulls low) |

## Verification
Several rules are checked on every cycle by the assertions. The pull-down enable never changes while the clock line is sampled high. No acknowledge is given while busy. The page stage never takes data during a commit. Writes move only the low four pointer bits. Read advances step the pointer by one with wrap. A busy period begins only after a commit request. The bench scenarios are needed for everything that depends on whole transactions. That covers the values read back after byte and page writes, overwriting inside a page, the pointer carried from one transaction to the next, the wrap from the last address to the first, and the engine staying silent after a bad code or a master non-acknowledge.

// File: rtl/ees_pkg.sv
package ees_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } link_state_t;

  typedef enum logic [1:0] {
    K_CTRL,
    K_ADDR,
    K_DATA
  } byte_kind_t;

  typedef enum logic [1:0] {
    PC_IDLE,
    PC_COPY,
    PC_HOLD
  } commit_state_t;
endpackage

// File: rtl/ees_line_sampler.sv
module ees_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_sync[SYNC_STAGES-1];
      sda_prev <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_lvl_o = scl_sync[SYNC_STAGES-1];
  assign sda_lvl_o = sda_sync[SYNC_STAGES-1];
  assign start_o   = scl_lvl_o & scl_prev & sda_prev & ~sda_lvl_o;
  assign stop_o    = scl_lvl_o & scl_prev & ~sda_prev & sda_lvl_o;
  assign rise_o    = scl_lvl_o & ~scl_prev;
  assign fall_o    = ~scl_lvl_o & scl_prev;
endmodule

// File: rtl/ees_protocol_fsm.sv
module ees_protocol_fsm
  import ees_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              scl_lvl_i,
  input  logic              sda_lvl_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              stage_we_o,
  output logic [ADDR_W-1:0] stage_addr_o,
  output logic [7:0]        stage_data_o,
  output logic              stage_clear_o,
  output logic              commit_o,
  output logic              sda_oe_o
);
  localparam int BLK_W = ADDR_W - 8;

  link_state_t       st;
  byte_kind_t        kind;
  logic [7:0]        rx_sh;
  logic [7:0]        tx_sh;
  logic [3:0]        bit_cnt;
  logic              is_read;
  logic              have_data;
  logic              mack_ok;
  logic              rd_step;
  logic [ADDR_W-1:0] ptr;

  assign rd_addr_o = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      kind          <= K_CTRL;
      rx_sh         <= '0;
      tx_sh         <= '0;
      bit_cnt       <= '0;
      is_read       <= 1'b0;
      have_data     <= 1'b0;
      mack_ok       <= 1'b0;
      rd_step       <= 1'b0;
      ptr           <= '0;
      sda_oe_o      <= 1'b0;
      stage_we_o    <= 1'b0;
      stage_addr_o  <= '0;
      stage_data_o  <= '0;
      stage_clear_o <= 1'b0;
      commit_o      <= 1'b0;
    end else begin
      stage_we_o    <= 1'b0;
      stage_clear_o <= 1'b0;
      commit_o      <= 1'b0;
      rd_step       <= 1'b0;
      if (start_i) begin
        st            <= ST_RX;
        kind          <= K_CTRL;
        bit_cnt       <= '0;
        sda_oe_o      <= 1'b0;
        have_data     <= 1'b0;
        stage_clear_o <= 1'b1;
      end else if (stop_i) begin
        commit_o  <= have_data;
        have_data <= 1'b0;
        st        <= ST_IDLE;
        sda_oe_o  <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_RX: begin
            if (rise_i && bit_cnt < 4'd8) begin
              rx_sh   <= {rx_sh[6:0], sda_lvl_i};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (fall_i && bit_cnt == 4'd8) begin
              unique case (kind)
                K_CTRL: begin
                  if (rx_sh[7:4] == DEV_CODE && !busy_i) begin
                    ptr[ADDR_W-1:8] <= rx_sh[BLK_W:1];
                    is_read         <= rx_sh[0];
                    sda_oe_o        <= 1'b1;
                    st              <= ST_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                K_ADDR: begin
                  ptr[7:0] <= rx_sh;
                  sda_oe_o <= 1'b1;
                  st       <= ST_ACK;
                end
                default: begin
                  stage_we_o           <= 1'b1;
                  stage_addr_o         <= ptr;
                  stage_data_o         <= rx_sh;
                  ptr[PAGE_W-1:0]      <= ptr[PAGE_W-1:0] + 1'b1;
                  have_data            <= 1'b1;
                  sda_oe_o             <= 1'b1;
                  st                   <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (fall_i) begin
              if (is_read) begin
                tx_sh    <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                bit_cnt  <= 4'd1;
                st       <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;
                bit_cnt  <= '0;
                kind     <= (kind == K_CTRL) ? K_ADDR : K_DATA;
                st       <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (fall_i) begin
              if (bit_cnt == 4'd8) begin
                sda_oe_o <= 1'b0;
                ptr      <= ptr + 1'b1;
                rd_step  <= 1'b1;
                st       <= ST_MACK;
              end else begin
                tx_sh    <= {tx_sh[6:0], 1'b0};
                sda_oe_o <= ~tx_sh[6];
                bit_cnt  <= bit_cnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (rise_i) begin
              mack_ok <= ~sda_lvl_i;
            end else if (fall_i) begin
              if (mack_ok) begin
                tx_sh    <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                bit_cnt  <= 4'd1;
                st       <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_lvl_i)); // R13
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK && kind == K_CTRL) |-> !busy_i); // R4
  AST_PAGE_ROLL: assert property (@(posedge clk) disable iff (rst)
    stage_we_o |-> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]) &&
                    ptr[PAGE_W-1:0] == $past(ptr[PAGE_W-1:0]) + 1'b1)); // R7
  AST_READ_STEP: assert property (@(posedge clk) disable iff (rst)
    rd_step |-> ptr == $past(ptr) + 1'b1); // R11
endmodule

// File: rtl/ees_page_commit.sv
module ees_page_commit
  import ees_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              clear_i,
  input  logic              commit_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o
);
  localparam int DEPTH = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  commit_state_t            st;
  logic [7:0]               stage_mem [DEPTH];
  logic [DEPTH-1:0]         vld;
  logic [ADDR_W-PAGE_W-1:0] page;
  logic [PAGE_W-1:0]        idx;
  logic [CNT_W-1:0]         cnt;

  assign busy_o = (st != PC_IDLE);

  always_ff @(posedge clk) begin
    if (wr_en_i && st == PC_IDLE) begin
      stage_mem[wr_addr_i[PAGE_W-1:0]] <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PC_IDLE;
      vld        <= '0;
      page       <= '0;
      idx        <= '0;
      cnt        <= '0;
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      mem_we_o <= 1'b0;
      unique case (st)
        PC_IDLE: begin
          if (clear_i) begin
            vld <= '0;
          end else if (wr_en_i) begin
            vld[wr_addr_i[PAGE_W-1:0]] <= 1'b1;
            page <= wr_addr_i[ADDR_W-1:PAGE_W];
          end else if (commit_i && |vld) begin
            idx <= '0;
            st  <= PC_COPY;
          end
        end
        PC_COPY: begin
          mem_we_o   <= vld[idx];
          mem_addr_o <= {page, idx};
          mem_data_o <= stage_mem[idx];
          idx        <= idx + 1'b1;
          if (idx == PAGE_W'(DEPTH - 1)) begin
            cnt <= '0;
            st  <= PC_HOLD;
          end
        end
        PC_HOLD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(WR_CYCLES - 1)) begin
            vld <= '0;
            st  <= PC_IDLE;
          end
        end
        default: st <= PC_IDLE;
      endcase
    end
  end

  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(commit_i)); // R8
  AST_NO_STAGE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !wr_en_i); // R4
endmodule

// File: rtl/ees_mem.sv
module ees_mem #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [7:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we_i) begin
      cells[waddr_i] <= wdata_i;
    end
    rdata_o <= cells[raddr_i];
  end
endmodule

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 4,
  parameter int WR_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic scl_lvl, sda_lvl, start_ev, stop_ev, rise_ev, fall_ev;
  logic busy, stage_we, stage_clear, commit, mem_we;
  logic [ADDR_W-1:0] rd_addr, stage_addr, mem_addr;
  logic [7:0] rd_data, stage_data, mem_data;

  ees_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl),
    .start_o(start_ev), .stop_o(stop_ev), .rise_o(rise_ev), .fall_o(fall_ev)
  );

  ees_protocol_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst(rst),
    .start_i(start_ev), .stop_i(stop_ev), .rise_i(rise_ev), .fall_i(fall_ev),
    .scl_lvl_i(scl_lvl), .sda_lvl_i(sda_lvl), .busy_i(busy),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .stage_we_o(stage_we), .stage_addr_o(stage_addr), .stage_data_o(stage_data),
    .stage_clear_o(stage_clear), .commit_o(commit), .sda_oe_o(sda_oe_o)
  );

  ees_page_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_commit (
    .clk(clk), .rst(rst),
    .wr_en_i(stage_we), .wr_addr_i(stage_addr), .wr_data_i(stage_data),
    .clear_i(stage_clear), .commit_i(commit), .busy_o(busy),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  ees_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we_i(mem_we), .waddr_i(mem_addr), .wdata_i(mem_data),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );
endmodule

// File: tb/eeprom_twi_slave_test.sv
`timescale 1ns/1ps
module eeprom_twi_slave_test;
  localparam int Q = 6;
  localparam int NV = 6;
  // {address[9:0], data[7:0]}
  localparam logic [17:0] VEC [NV] = '{18'h0125A, 18'h15511, 18'h15622,
                                       18'h2A7C3, 18'h3C07E, 18'h0FF81};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  eeprom_twi_slave uut (.clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); r = sda_line; tick(Q); scl_m = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(v[i], r);
    bit_xfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, r);
      v[i] = r;
    end
    bit_xfer(~mack, r);
  endtask

  function automatic logic [7:0] ctrl(input logic b2, input logic [9:0] a, input logic rw);
    return {4'b1010, b2, a[9:8], rw};
  endfunction

  task automatic write_run(input logic [9:0] a, input int n, input logic [7:0] base, input logic b2);
    logic ack;
    bus_start();
    put_byte(ctrl(b2, a, 1'b0), ack); chk("R3 ctrl ack", ack, 1);
    put_byte(a[7:0], ack);            chk("R3 addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      put_byte(base + 8'(i), ack);    chk("R3 data ack", ack, 1);
    end
    bus_stop();
  endtask

  task automatic wait_ready();
    logic ack;
    for (int k = 0; k < 40; k++) begin
      bus_start();
      put_byte(ctrl(1'b0, 10'h0, 1'b0), ack);
      bus_stop();
      if (ack) break;
    end
  endtask

  task automatic read_setup(input logic [9:0] a);
    logic ack;
    bus_start();
    put_byte(ctrl(1'b0, a, 1'b0), ack); chk("R10 ctrl ack", ack, 1);
    put_byte(a[7:0], ack);              chk("R6 addr ack", ack, 1);
    bus_start();
    put_byte(ctrl(1'b0, a, 1'b1), ack); chk("R10 read ctrl ack", ack, 1);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic ack, r;
    logic [7:0] v;
    tick(5);
    chk("R13 oe in reset", sda_oe, 0);
    rst = 1'b0;
    tick(5);
    chk("R13 oe after reset", sda_oe, 0);

    // R2: wrong device code, then a byte without start
    bus_start();
    put_byte(8'hB0, ack); chk("R2 bad code nack", ack, 0);
    put_byte(8'hA0, ack); chk("R2 ignored until start", ack, 0);
    bus_stop();

    // R1: start inside a byte restarts reception
    bus_start();
    bit_xfer(1'b1, r); bit_xfer(1'b0, r); bit_xfer(1'b1, r);
    bus_start();
    put_byte(ctrl(1'b0, 10'h0, 1'b0), ack); chk("R1 restart ack", ack, 1);
    bus_stop();

    // table of byte writes; b2 alternates (R5)
    for (int i = 0; i < NV; i++) begin
      write_run(VEC[i][17:8], 1, VEC[i][7:0], 1'(i % 2));
      if (i == 0) begin
        bus_start();
        put_byte(ctrl(1'b0, 10'h0, 1'b0), ack); chk("R4 busy nack", ack, 0);
        bus_stop();
      end
      wait_ready();
    end
    for (int i = 0; i < NV; i++) begin
      read_setup(VEC[i][17:8]);
      get_byte(1'b0, v);
      chk("R10 R5 readback", v, VEC[i][7:0]);
      bus_stop();
    end

    // R9: current-address read after a random read of 0x155
    read_setup(10'h155);
    get_byte(1'b0, v);
    bus_stop();
    bus_start();
    put_byte(ctrl(1'b0, 10'h156, 1'b1), ack); chk("R9 ctrl ack", ack, 1);
    get_byte(1'b0, v); chk("R9 current read", v, 8'h22);
    bus_stop();

    // R8: address-only write changes nothing and is not busy
    write_run(10'h012, 0, 8'h00, 1'b0);
    bus_start();
    put_byte(ctrl(1'b0, 10'h0, 1'b0), ack); chk("R8 no busy after addr-only", ack, 1);
    bus_stop();
    read_setup(10'h012);
    get_byte(1'b0, v); chk("R8 memory unchanged", v, 8'h5A);
    bus_stop();

    // R7: 18 bytes from 0x2FE roll inside the page
    write_run(10'h2FE, 18, 8'h40, 1'b0);
    wait_ready();
    read_setup(10'h2F0);
    for (int k = 0; k < 16; k++) begin
      get_byte(k != 15, v);
      chk("R7 R11 page roll", v, (k < 14) ? 16'(8'h42 + k) : 16'(8'h50 + k - 14));
    end
    tick(Q);
    chk("R12 released after nack", sda_oe, 0);
    tick(2*Q);
    chk("R12 still released", sda_oe, 0);
    bus_stop();

    // R11: sequential read wraps from 1023 to 0
    write_run(10'h3FE, 2, 8'hC1, 1'b0);
    wait_ready();
    write_run(10'h000, 2, 8'hD1, 1'b1);
    wait_ready();
    read_setup(10'h3FE);
    get_byte(1'b1, v); chk("R11 byte 1022", v, 8'hC1);
    get_byte(1'b1, v); chk("R11 byte 1023", v, 8'hC2);
    get_byte(1'b1, v); chk("R11 wrap byte 0", v, 8'hD1);
    get_byte(1'b0, v); chk("R11 byte 1", v, 8'hD2);
    bus_stop();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule